// File: doc/BRIEF.md
# Serial Write-Only Configuration Register Bank

This block is a serial slave that receives configuration writes over three wires: a serial clock, an active-low load strobe and one data line. Each write frame carries a 4-bit register index followed by a 10-bit value, both sent most significant bit first. The value goes into one of sixteen internal registers only after a full frame and one extra low-strobe cycle. A frame that ends early is dropped and changes nothing.

Each register has its own width, up to 10 bits, and its own reset value, both set by parameters. A narrow register keeps only the low-order bits of the value it receives. All register contents are driven on a flat parallel output. A one-cycle pulse reports each committed write together with its register index. The reset input is asynchronous and acts only while the strobe is also low. In that state every register returns to its reset value, and the interface must see the strobe high once before the next frame can begin.

Top module: `serialRegBank`

## Requirements
- R1: Strobe and data are sampled on rising edges of `sclk`. With the interface armed, the first low-strobe edge starts a frame. Low edges 1 to 4 shift in the index, bit 3 first. Low edges 5 to 14 shift in the value, bit 9 first. On low edge 15 the value is written into register `index`, which appears on `regOut[index*10 +: 10]`.
- R2: The write of R1 raises `wrPulse` for exactly one cycle, starting at the commit edge, with `wrAddr` equal to the index. No other edge raises `wrPulse`.
- R3: If the strobe is sampled high on any edge before the 15th low edge, the frame is abandoned. No register changes and `wrPulse` stays low.
- R4: Low-strobe edges after the commit edge cause no further write and no further pulse until the strobe has been sampled high.
- R5: A single high-strobe edge between two frames is enough, so back-to-back frames each commit.
- R6: After reset, low-strobe edges start no frame until the strobe has been sampled high at least once.
- R7: A register of width W stores only bits W-1..0 of the received value, and its upper output bits read 0. With default parameters register 1 is 6 bits wide, register 3 is 1 bit wide, and all other registers are 10 bits wide.
- R8: While `rstN` and `loadN` are both low, every register holds its default value masked to its width, without waiting for a clock edge. The default value is 10'h2A5 for every register. `rstN` low with `loadN` high has no effect.
- R9: A write changes only the register at its index. All other registers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock; all frame activity happens on its rising edge |
| rstN | input | 1 | Asynchronous reset, active low; acts only while loadN is also low |
| loadN | input | 1 | Active-low load strobe framing each write |
| sdi | input | 1 | Serial data, index then value, MSB first |
| regOut | output | 160 | All registers; register i at bits [i*10 +: 10] |
| wrPulse | output | 1 | One-cycle pulse after each committed write |
| wrAddr | output | 4 | Index of the write reported by wrPulse |

## Verification
A wrong bit counter or a lost armed flag shows up as a missing `wrPulse`, or a pulse one edge early or late, in the cycle after the 15th low edge. It also shows as a second pulse when the strobe is held low past the commit edge. A shift or field mix-up shows in that same cycle as a wrong `wrAddr`, or as a changed value on a register that was not addressed. Reset faults are visible within half a clock period, because the registers must take their defaults before any edge arrives.

// File: rtl/swrPkg.sv
package swrPkg;
  typedef struct packed {
    logic shiftEn;
    logic commitEn;
  } swrStrobes_t;
endpackage

// File: rtl/swrCtrl.sv
module swrCtrl
  import swrPkg::*;
#(
  parameter int FRAME_BITS = 14
) (
  input  logic        clk,
  input  logic        rstAsync,
  input  logic        loadN,
  output swrStrobes_t strobes
);
  localparam int CNT_W = $clog2(FRAME_BITS + 2);
  localparam logic [CNT_W-1:0] LAST_SHIFT = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] DONE = CNT_W'(FRAME_BITS + 1);

  logic [CNT_W-1:0] cnt;
  logic             armed;

  always_comb begin
    strobes.shiftEn  = !loadN && (((cnt == '0) && armed) ||
                                  ((cnt != '0) && (cnt < LAST_SHIFT)));
    strobes.commitEn = !loadN && (cnt == LAST_SHIFT);
  end

  always_ff @(posedge clk or posedge rstAsync) begin
    if (rstAsync) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else if (loadN) begin
      cnt   <= '0;
      armed <= 1'b1;
    end else if (strobes.shiftEn) begin
      cnt   <= cnt + 1'b1;
      armed <= 1'b0;
    end else if (strobes.commitEn) begin
      cnt   <= DONE;
    end
  end
endmodule

// File: rtl/swrDatapath.sv
module swrDatapath
  import swrPkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 10,
  parameter logic [(2**ADDR_W)*8-1:0] REG_WIDTHS = {(2**ADDR_W){8'd10}},
  parameter logic [(2**ADDR_W)*DATA_W-1:0] REG_DEFAULTS = '0
) (
  input  logic                           clk,
  input  logic                           rstAsync,
  input  logic                           sdi,
  input  swrStrobes_t                    strobes,
  output logic [(2**ADDR_W)*DATA_W-1:0]  regOut,
  output logic                           wrPulse,
  output logic [ADDR_W-1:0]              wrAddr
);
  localparam int NUM_REGS   = 2**ADDR_W;
  localparam int FRAME_BITS = ADDR_W + DATA_W;

  logic [FRAME_BITS-1:0] shiftQ;
  logic [ADDR_W-1:0]     frameAddr;
  logic [DATA_W-1:0]     frameData;

  assign frameAddr = shiftQ[FRAME_BITS-1 -: ADDR_W];
  assign frameData = shiftQ[DATA_W-1:0];

  always_ff @(posedge clk or posedge rstAsync) begin
    if (rstAsync) begin
      shiftQ  <= '0;
      wrPulse <= 1'b0;
      wrAddr  <= '0;
    end else begin
      if (strobes.shiftEn) shiftQ <= {shiftQ[FRAME_BITS-2:0], sdi};
      wrPulse <= strobes.commitEn;
      if (strobes.commitEn) wrAddr <= frameAddr;
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : gReg
    localparam int W = int'(REG_WIDTHS[g*8 +: 8]);
    localparam logic [DATA_W-1:0] MASK = {DATA_W{1'b1}} >> (DATA_W - W);
    localparam logic [DATA_W-1:0] DEF = REG_DEFAULTS[g*DATA_W +: DATA_W] & MASK;
    logic [DATA_W-1:0] regQ;

    always_ff @(posedge clk or posedge rstAsync) begin
      if (rstAsync) regQ <= DEF;
      else if (strobes.commitEn && (frameAddr == ADDR_W'(g))) regQ <= frameData & MASK;
    end

    assign regOut[g*DATA_W +: DATA_W] = regQ;
  end
endmodule

// File: rtl/serialRegBank.sv
module serialRegBank
  import swrPkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 10,
  parameter logic [(2**ADDR_W)*8-1:0] REG_WIDTHS = {{12{8'd10}}, 8'd1, 8'd10, 8'd6, 8'd10},
  parameter logic [(2**ADDR_W)*DATA_W-1:0] REG_DEFAULTS = {(2**ADDR_W){10'h2A5}}
) (
  input  logic                          sclk,
  input  logic                          rstN,
  input  logic                          loadN,
  input  logic                          sdi,
  output logic [(2**ADDR_W)*DATA_W-1:0] regOut,
  output logic                          wrPulse,
  output logic [ADDR_W-1:0]             wrAddr
);
  localparam int FRAME_BITS = ADDR_W + DATA_W;

  logic        rstAsync;
  swrStrobes_t strobes;

  assign rstAsync = !rstN && !loadN;

  swrCtrl #(.FRAME_BITS(FRAME_BITS)) u_ctrl (
    .clk      (sclk),
    .rstAsync (rstAsync),
    .loadN    (loadN),
    .strobes  (strobes)
  );

  swrDatapath #(
    .ADDR_W       (ADDR_W),
    .DATA_W       (DATA_W),
    .REG_WIDTHS   (REG_WIDTHS),
    .REG_DEFAULTS (REG_DEFAULTS)
  ) u_dp (
    .clk      (sclk),
    .rstAsync (rstAsync),
    .sdi      (sdi),
    .strobes  (strobes),
    .regOut   (regOut),
    .wrPulse  (wrPulse),
    .wrAddr   (wrAddr)
  );
endmodule

// File: rtl/serialRegBankChecker.sv
module serialRegBankChecker #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 10
) (
  input logic                          sclk,
  input logic                          rstN,
  input logic                          loadN,
  input logic [(2**ADDR_W)*DATA_W-1:0] regOut,
  input logic                          wrPulse
);
  logic resetCond;
  assign resetCond = !rstN && !loadN;

  // R2: the write pulse lasts one cycle only
  assert_pulse_single_R2: assert property (@(posedge sclk) disable iff (resetCond)
    wrPulse |=> !wrPulse);

  // R1: a commit happens only on an edge where the strobe was low
  assert_commit_low_R1: assert property (@(posedge sclk) disable iff (resetCond)
    wrPulse |-> $past(!loadN));

  // R3: a high strobe edge never yields a write
  assert_high_no_write_R3: assert property (@(posedge sclk) disable iff (resetCond)
    loadN |=> !wrPulse);

  // R9: register contents move only together with a write pulse
  assert_regs_stable_R9: assert property (@(posedge sclk) disable iff (resetCond)
    !wrPulse |-> $stable(regOut));
endmodule

bind serialRegBank serialRegBankChecker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .sclk    (sclk),
  .rstN    (rstN),
  .loadN   (loadN),
  .regOut  (regOut),
  .wrPulse (wrPulse)
);

// File: tb/serialRegBank_bench.sv
`timescale 1ns/100ps
module serialRegBank_bench;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 10;
  localparam int NREG = 16;

  logic sclk = 1'b0;
  logic rstN = 1'b0;
  logic loadN = 1'b0;
  logic sdi = 1'b0;
  logic [NREG*DATA_W-1:0] regOut;
  logic wrPulse;
  logic [ADDR_W-1:0] wrAddr;

  int checks = 0;
  int errors = 0;
  logic [DATA_W-1:0] model [NREG];
  logic [ADDR_W+DATA_W-1:0] expQ [$];

  always #2 sclk = ~sclk;

  serialRegBank u_serialRegBank (
    .sclk(sclk), .rstN(rstN), .loadN(loadN), .sdi(sdi),
    .regOut(regOut), .wrPulse(wrPulse), .wrAddr(wrAddr)
  );

  function automatic logic [DATA_W-1:0] maskOf(int i, logic [DATA_W-1:0] v);
    int w;
    w = (i == 1) ? 6 : (i == 3) ? 1 : 10;
    return v & ({DATA_W{1'b1}} >> (DATA_W - w));
  endfunction

  task automatic loadDefaults();
    for (int i = 0; i < NREG; i++) model[i] = maskOf(i, 10'h2A5);
  endtask

  task automatic checkAll(string tag);
    for (int i = 0; i < NREG; i++) begin
      checks++;
      if (regOut[i*DATA_W +: DATA_W] !== model[i]) begin
        errors++;
        $display("FAIL %s reg %0d actual %h expected %h", tag, i,
                 regOut[i*DATA_W +: DATA_W], model[i]);
      end
    end
  endtask

  // monitor: each pulse must match the oldest expected write
  always @(negedge sclk) begin
    if (wrPulse) begin
      logic [ADDR_W+DATA_W-1:0] e;
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL R2/R4/R6 unexpected pulse addr %0d actual 1 expected 0", wrAddr);
      end else begin
        e = expQ.pop_front();
        if (wrAddr !== e[DATA_W +: ADDR_W] ||
            regOut[int'(e[DATA_W +: ADDR_W])*DATA_W +: DATA_W] !==
              maskOf(int'(e[DATA_W +: ADDR_W]), e[DATA_W-1:0])) begin
          errors++;
          $display("FAIL R1/R2 addr actual %0d expected %0d data actual %h expected %h",
                   wrAddr, e[DATA_W +: ADDR_W],
                   regOut[int'(e[DATA_W +: ADDR_W])*DATA_W +: DATA_W],
                   maskOf(int'(e[DATA_W +: ADDR_W]), e[DATA_W-1:0]));
        end
      end
    end
  end

  // driver: lowCycles strobe-low edges, then one high edge
  task automatic sendFrame(logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d, int lowCycles);
    if (lowCycles >= ADDR_W + DATA_W + 1) begin
      expQ.push_back({a, d});
      model[a] = maskOf(int'(a), d);
    end
    for (int i = 1; i <= lowCycles; i++) begin
      @(negedge sclk);
      loadN = 1'b0;
      if (i <= ADDR_W) sdi = a[ADDR_W-i];
      else if (i <= ADDR_W + DATA_W) sdi = d[ADDR_W+DATA_W-i];
      else sdi = i[0];
    end
    @(negedge sclk);
    loadN = 1'b1;
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    loadDefaults();
    repeat (3) @(negedge sclk);
    checkAll("R8 R7 reset defaults");
    rstN = 1'b1;
    // R6: strobe never high since reset, so no frame starts
    for (int i = 0; i < 20; i++) begin
      @(negedge sclk);
      sdi = i[1];
    end
    checkAll("R6 no frame before arm");
    @(negedge sclk);
    loadN = 1'b1;

    sendFrame(4'd5, 10'h3A7, 15);
    checkAll("R1 R9 basic write");
    sendFrame(4'd1, 10'h3FF, 15);
    sendFrame(4'd3, 10'h002, 15);
    checkAll("R7 narrow regs");

    sendFrame(4'd6, 10'h111, 14);
    sendFrame(4'd6, 10'h222, 3);
    sendFrame(4'd6, 10'h333, 1);
    checkAll("R3 aborted frames");

    sendFrame(4'd9, 10'h0F0, 25);
    checkAll("R4 extra low cycles");

    // R5: back-to-back frames with a single high edge between
    sendFrame(4'd0, 10'h155, 15);
    sendFrame(4'd15, 10'h2AA, 15);
    sendFrame(4'd0, 10'h001, 15);
    sendFrame(4'd7, 10'h3C3, 15);
    checkAll("R5 back to back");

    // R8: reset low with strobe high does nothing
    @(negedge sclk);
    rstN = 1'b0;
    repeat (5) @(negedge sclk);
    checkAll("R8 rstN low strobe high");
    rstN = 1'b1;

    // R8: asynchronous load of defaults between edges
    #1;
    rstN = 1'b0;
    loadN = 1'b0;
    #0.5;
    loadDefaults();
    checkAll("R8 async defaults");
    @(negedge sclk);
    @(negedge sclk);
    rstN = 1'b1;
    // R6: strobe kept low after reset, frame bits must be ignored
    for (int i = 0; i < 16; i++) begin
      @(negedge sclk);
      sdi = 1'b1;
    end
    checkAll("R6 no frame after reset");
    @(negedge sclk);
    loadN = 1'b1;
    sendFrame(4'd12, 10'h05A, 15);
    checkAll("R1 write after reset");

    repeat (3) @(negedge sclk);
    checks++;
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL R1/R2 missing pulses actual %0d expected 0", expQ.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule